// File: doc/BRIEF.md
# 16-to-1 Serializer with Word-Clock Timing Generator

This block turns a stream of 16-bit words into a bit-serial stream that runs at the bit-clock rate. A single modulo-16 phase counter produces three signals. The first is a one-cycle load strobe that copies the incoming word into a loadable shift register. The second is a divide-by-16 word clock that upstream framing logic runs on. The third is a reference-rate feedback clock for the phase comparator of a clock synthesizer. The serial output, the word clock and the load strobe all come from that one counter, so they keep a fixed phase relationship to each other.

Upstream logic presents the next word on `word_i` and holds it through the cycle in which `load_o` is high. The word is captured on the clock edge that ends that cycle. Its bits then leave on `ser_o` most-significant first, one per bit clock. The last bit of one word is followed at once by the first bit of the next.

Top module: `serializer_tx`

## Requirements
- R1: While `rst_ni` is low, `ser_o`, `load_o`, `pclk_o` and `fb_clk_o` are all 0.
- R2: `load_o` is high for exactly one bit-clock cycle out of every 16. Its first assertion is in the cycle after the 8th rising clock edge following reset release.
- R3: The word on `word_i` during a `load_o` cycle is captured at the edge that ends that cycle. `ser_o` then carries bit 15 in the next cycle, bit 14 in the cycle after, and so on down to bit 0 in the cycle in which `load_o` is high again.
- R4: `pclk_o` has a period of 16 bit clocks, with 8 cycles high and 8 cycles low. It rises on the same edge on which `load_o` goes high, so it is high in the load cycle and in the 7 cycles after it.
- R5: `fb_clk_o` is the bit clock divided by `FB_DIV` (16 by default), with a 50% duty cycle. At the default divide it is in phase with `pclk_o`.
- R6: After reset release, `ser_o` stays 0 until the first word has been loaded.
- R7: Values on `word_i` in cycles where `load_o` is low have no effect on `ser_o`.
- R8: Consecutive words are sent back to back, with no idle bit between the last bit of one word and the first bit of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | 16 | Parallel word from the decoupling FIFO |
| ser_o | output | 1 | Serial data, MSB first |
| pclk_o | output | 1 | Divide-by-16 word clock for upstream logic |
| load_o | output | 1 | One-cycle load strobe into the shift register |
| fb_clk_o | output | 1 | Reference-rate feedback clock for the synthesizer |

## Verification
The bench drives changing garbage on `word_i` in every cycle except the load cycle. A design that sampled the word one cycle early or one cycle late would then put the wrong bits on the line. Words with a single set bit at either end (0x8001) and alternating patterns expose bit-order reversal and off-by-one shift counts. Running many words back to back catches a shift register that inserts an idle bit or drops bit 0. An independent phase model checks `pclk_o` and `fb_clk_o` in every cycle, including the first word-clock rise after reset and the behaviour after a mid-stream reset. A counter with the wrong reset phase would show up there as a word clock that rises away from the load strobe.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  localparam int unsigned SER_WORD_W = 16;
  localparam int unsigned SER_FB_DIV = 16;

  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/ser_timing_gen.sv
`timescale 1ns/1ps
module ser_timing_gen #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W,
  parameter int unsigned FB_DIV = ser_pkg::SER_FB_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic pclk_o,
  output logic fb_clk_o
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam int unsigned FW = $clog2(FB_DIV);
  localparam logic [CW-1:0] CNT_RST  = CW'(WORD_W/2 - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] HALF_W   = CW'(WORD_W/2);

  initial begin
    if (!ser_pkg::is_pow2(WORD_W) || !ser_pkg::is_pow2(FB_DIV) || FB_DIV > WORD_W)
      $error("ser_timing_gen: WORD_W and FB_DIV must be powers of two, FB_DIV <= WORD_W");
  end

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_ahead;
  logic          pclk_d, pclk_q;

  // reset phase chosen so the first word-clock rise lands on the first load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_RST;
    else         cnt_q <= cnt_q + CW'(1);
  end

  assign load_o    = (cnt_q == CNT_LAST);
  // register input looks one count ahead of the value being loaded
  assign cnt_ahead = cnt_q + CW'(2);
  assign pclk_d    = (cnt_ahead < HALF_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pclk_q <= 1'b0;
    else         pclk_q <= pclk_d;
  end
  assign pclk_o = pclk_q;

  generate
    if (FB_DIV == WORD_W) begin : g_fb_same
      assign fb_clk_o = pclk_q;
    end else begin : g_fb_sub
      localparam logic [FW-1:0] FB_HALF = FW'(FB_DIV/2);
      logic [FW-1:0] fb_ahead;
      logic          fb_q;
      assign fb_ahead = cnt_q[FW-1:0] + FW'(2);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fb_q <= 1'b0;
        else         fb_q <= (fb_ahead < FB_HALF);
      end
      assign fb_clk_o = fb_q;
    end
  endgenerate

  // assertion support: cycles since the previous strobe
  logic [CW:0] since_ld_q;
  logic        seen_ld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_ld_q <= '0;
      seen_ld_q  <= 1'b0;
    end else if (load_o) begin
      since_ld_q <= '0;
      seen_ld_q  <= 1'b1;
    end else begin
      since_ld_q <= since_ld_q + (CW+1)'(1);
    end
  end

  a_r2_load_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  a_r2_load_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && seen_ld_q) |-> (since_ld_q == (CW+1)'(WORD_W - 1)));
  a_r4_pclk_high_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> pclk_o);
endmodule

// File: rtl/ser_shift_reg.sv
`timescale 1ns/1ps
module ser_shift_reg #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o
);
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sreg_q <= '0;
    else if (load_i) sreg_q <= word_i;
    else             sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
  end

  assign ser_o = sreg_q[WORD_W-1];

  a_r3_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ser_o == $past(word_i[WORD_W-1])));
endmodule

// File: rtl/serializer_tx.sv
`timescale 1ns/1ps
module serializer_tx #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W,
  parameter int unsigned FB_DIV = ser_pkg::SER_FB_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o,
  output logic              pclk_o,
  output logic              load_o,
  output logic              fb_clk_o
);
  logic load_w;

  ser_timing_gen #(.WORD_W(WORD_W), .FB_DIV(FB_DIV)) u_tgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_o   (load_w),
    .pclk_o   (pclk_o),
    .fb_clk_o (fb_clk_o)
  );

  ser_shift_reg #(.WORD_W(WORD_W)) u_sreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .word_i (word_i),
    .ser_o  (ser_o)
  );

  assign load_o = load_w;

  a_r4_pclk_rise_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pclk_o) |-> load_o);
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rst_ni) && !load_o) |=> !ser_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!ser_o && !pclk_o && !load_o && !fb_clk_o);
    end
  end
endmodule

// File: tb/serializer_tx_tb_top.sv
`timescale 1ns/1ps
module serializer_tx_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] word_i = 16'h0;
  logic        ser_o, pclk_o, load_o, fb_clk_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  bit exp_q[$];
  int word_idx = 0;

  always #2.5 clk_i = ~clk_i;

  serializer_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_i),
    .ser_o(ser_o), .pclk_o(pclk_o), .load_o(load_o), .fb_clk_o(fb_clk_o)
  );

  function automatic logic [15:0] pick_word(input int i);
    case (i)
      0: return 16'h8001;
      1: return 16'hFFFF;
      2: return 16'h0000;
      3: return 16'hAAAA;
      4: return 16'h5555;
      5: return 16'h0001;
      6: return 16'h8000;
      default: return 16'(i * 40503) ^ 16'h3C5A;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // driver + monitor at the falling edge; k = rising edges since reset release
  task automatic run_cycles(input int ncyc);
    bit loaded = 0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk_i);
      begin
        int ph = (7 + k) % 16;
        logic exp_ld = (ph == 15);
        logic exp_pc = (((ph + 1) % 16) < 8);
        check("R2", load_o, exp_ld, "load strobe");
        check("R4", pclk_o, exp_pc, "word clock");
        check("R5", fb_clk_o, exp_pc, "feedback clock");
        if (exp_q.size() > 0) begin
          logic eb = exp_q.pop_front();
          check(loaded ? "R3/R8" : "R3", ser_o, eb, "serial bit");
        end else begin
          check("R6", ser_o, 1'b0, "idle serial");
        end
        if (load_o) begin
          logic [15:0] w = pick_word(word_idx++);
          word_i = w;
          for (int b = 15; b >= 0; b--) exp_q.push_back(w[b]);
          loaded = 1;
        end else begin
          // R7: garbage outside the load cycle must not reach ser_o
          word_i = 16'(k * 7919) ^ 16'hDEAD;
        end
      end
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1", ser_o, 1'b0, "reset ser");
    check("R1", pclk_o, 1'b0, "reset pclk");
    check("R1", load_o, 1'b0, "reset load");
    check("R1", fb_clk_o, 1'b0, "reset fb");
    rst_ni = 1'b1;
    run_cycles(16 * 14 + 8);

    // mid-stream reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", ser_o, 1'b0, "mid reset ser");
    check("R1", pclk_o, 1'b0, "mid reset pclk");
    check("R1", load_o, 1'b0, "mid reset load");
    exp_q.delete();
    word_idx = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_cycles(16 * 4 + 8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule